// File: doc/BRIEF.md
# Serial Port Host Register File

This block is the processor-side register set of a 16550-compatible serial port. A byte-wide bus reaches eight registers. The bus offset is found by shifting the address right by a fixed stride, so the registers can be placed one per byte, one per halfword or one per word. Software uses this set to do four things:

- program the baud divisor and the frame format;
- move bytes to a transmitter and from a receiver;
- read fixed line and modem status;
- take a single interrupt request line, whose cause it reads from the identification register.

The block does not serialise bits and holds no FIFO. On the transmit side it hands each written byte to a transmitter as a one-cycle push. On the receive side it pops bytes from a receiver that reports when data is available. A loopback mode sends written bytes into a one-byte loop buffer instead. Software then reads them back through the normal receive path.

Top module: `uart_host_regs`

## Requirements
- R1: The register offset is bits [2:0] of the bus address after it is shifted right by STRIDE_SHIFT. Other address bits below the stride have no effect.
- R2: After reset the registers hold these values, and `irq` is low:
  - the divisor holds 12;
  - line control reads 0x03 (8 data bits, no parity, 1 stop bit);
  - interrupt enable and modem control read 0x00;
  - the identification register reads 0x01.
- R3: While line-control bit 7 is 1, offset 0 reads and writes divisor bits [7:0] and offset 1 reads and writes divisor bits [15:0]'s upper byte. These accesses push nothing to the transmitter and leave interrupt enable unchanged. While bit 7 is 0, offset 1 reads back the last value written to interrupt enable.
- R4: Offset 5 (line status) reads 0x60 plus bit 0 = receive ready. Writes to it have no effect.
- R5: Offset 6 (modem status) reads 0xB0 (bit 7 carrier detect, bit 5 data set ready, bit 4 clear to send). Writes to it have no effect.
- R6: A data write (offset 0, bit 7 of line control clear, loopback off) raises `tx_push` for that one cycle, with `tx_byte` equal to the written byte. Every data write sets the transmit-ready source.
- R7: With modem-control bit 4 (loopback) set, a data write stores the byte in the loop buffer and does not push. In this mode receive ready is the loop-buffer-full flag. A data read returns the stored byte and empties the buffer.
- R8: With loopback off, a data read returns `rx_byte` and raises `rx_pop` for that cycle when `rx_avail` is high. When `rx_present` is low, a data read returns 0 and does not pop.
- R9: Offset 2 reads the identification register:
  - bit 0 = 1 means no interrupt is pending;
  - 0x04 means receive ready (highest priority), 0x02 means transmit ready;
  - bits [7:6] both copy bit 0 of the value last written to offset 2.
  A read that returns the transmit-ready code clears the transmit-ready source.
- R10: An interrupt-enable write that changes bit 1 (transmit enable) from 0 to 1 sets the transmit-ready source. A write that leaves bit 1 at 1 does not set it.
- R11: An interrupt is pending when receive ready and interrupt-enable bit 0 are both set, or when the transmit-ready source and interrupt-enable bit 1 are both set. `irq` is a register that holds (pending AND modem-control bit 3) from the cycle before.
- R12: Offset 7 stores the written byte and returns it on read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address within the block |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the access cycle |
| irq | output | 1 | Interrupt request |
| tx_push | output | 1 | Byte handed to transmitter |
| tx_byte | output | 8 | Transmit byte |
| rx_pop | output | 1 | Byte taken from receiver |
| rx_byte | input | 8 | Receiver head byte |
| rx_avail | input | 1 | Receiver has a byte |
| rx_present | input | 1 | Receiver is attached |

## Verification
The assertions assume that each bus access lasts one cycle and that a single access is never both an identification read and a data write. They also assume that `rx_avail` changes only between accesses. The bench drives every access as a single-cycle strobe set up on the falling edge. It changes the receiver inputs only while the bus is idle, so the receive-ready source stays steady across each read and its pop.

// File: rtl/uart_host_pkg.sv
package uart_host_pkg;
  typedef enum logic [2:0] {
    OFF_DATA = 3'd0, OFF_IER = 3'd1, OFF_IIR = 3'd2, OFF_LCR = 3'd3,
    OFF_MCR  = 3'd4, OFF_LSR = 3'd5, OFF_MSR = 3'd6, OFF_SCR = 3'd7
  } reg_off_e;

  typedef struct packed {
    logic     rd;
    logic     wr;
    reg_off_e off;
  } bus_op_t;

  localparam int LCR_DLAB = 7;
  localparam int MCR_OUT2 = 3;
  localparam int MCR_LOOP = 4;
  localparam int IER_RX   = 0;
  localparam int IER_TX   = 1;

  localparam logic [7:0] LCR_RESET   = 8'h03;
  localparam logic [7:0] LSR_TX_IDLE = 8'h60;
  localparam logic [7:0] MSR_FIXED   = 8'hB0;
  localparam logic [3:0] ID_NONE     = 4'h1;
  localparam logic [3:0] ID_TX       = 4'h2;
  localparam logic [3:0] ID_RX       = 4'h4;
endpackage

// File: rtl/uart_host_decode.sv
module uart_host_decode
  import uart_host_pkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter int STRIDE_SHIFT = 0
) (
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  output bus_op_t           op_o
);
  localparam int MIN_W = STRIDE_SHIFT + 3;

  logic [ADDR_W-1:0] scaled;

  always_comb begin
    scaled   = addr_i >> STRIDE_SHIFT;
    op_o.rd  = sel_i & ~wr_i;
    op_o.wr  = sel_i & wr_i;
    op_o.off = reg_off_e'(scaled[2:0]);
  end

  initial begin
    if (ADDR_W < MIN_W) $error("ADDR_W too small for STRIDE_SHIFT");
  end
endmodule

// File: rtl/uart_host_rxpath.sv
module uart_host_rxpath #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              loop_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] rx_byte_i,
  input  logic              rx_avail_i,
  input  logic              rx_present_i,
  output logic              rx_ready_o,
  output logic [DATA_W-1:0] rd_byte_o,
  output logic              rx_pop_o
);
  logic              lb_full_q, lb_full_d;
  logic [DATA_W-1:0] lb_byte_q, lb_byte_d;
  logic              lb_en;

  always_comb begin
    lb_full_d = lb_full_q;
    lb_byte_d = lb_byte_q;
    lb_en     = 1'b0;
    if (loop_i && wr_i) begin
      lb_full_d = 1'b1;
      lb_byte_d = wdata_i;
      lb_en     = 1'b1;
    end else if (loop_i && rd_i) begin
      lb_full_d = 1'b0;
      lb_en     = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lb_full_q <= 1'b0;
      lb_byte_q <= '0;
    end else if (lb_en) begin
      lb_full_q <= lb_full_d;
      lb_byte_q <= lb_byte_d;
    end
  end

  always_comb begin
    if (loop_i) begin
      rx_ready_o = lb_full_q;
      rd_byte_o  = lb_full_q ? lb_byte_q : '0;
      rx_pop_o   = 1'b0;
    end else begin
      rx_ready_o = rx_present_i & rx_avail_i;
      rd_byte_o  = rx_present_i ? rx_byte_i : '0;
      rx_pop_o   = rd_i & rx_present_i & rx_avail_i;
    end
  end

  // R7: a loopback read leaves the buffer empty
  assert_loop_drain_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_i && rd_i) |=> !lb_full_q);
  // R7: a loopback write fills the buffer
  assert_loop_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_i && wr_i) |=> (lb_full_q && lb_byte_q == $past(wdata_i)));
endmodule

// File: rtl/uart_host_irq.sv
module uart_host_irq
  import uart_host_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] ier_i,
  input  logic       ier_wr_i,
  input  logic       ier_wtx_i,
  input  logic       tx_set_i,
  input  logic       rx_ready_i,
  input  logic       iir_rd_i,
  input  logic       fifo_on_i,
  input  logic       gate_i,
  output logic [7:0] iir_o,
  output logic       irq_o
);
  logic tx_src_q, tx_src_d;
  logic irq_q, irq_d;
  logic pend_rx, pend_tx;
  logic [3:0] id;

  always_comb begin
    pend_rx = ier_i[IER_RX] & rx_ready_i;
    pend_tx = ier_i[IER_TX] & tx_src_q;
    if (pend_rx)      id = ID_RX;
    else if (pend_tx) id = ID_TX;
    else              id = ID_NONE;
    iir_o = {fifo_on_i, fifo_on_i, 2'b00, id};

    tx_src_d = tx_src_q;
    if (tx_set_i || (ier_wr_i && ier_wtx_i && !ier_i[IER_TX]))
      tx_src_d = 1'b1;
    else if (iir_rd_i && !pend_rx && pend_tx)
      tx_src_d = 1'b0;

    irq_d = (pend_rx | pend_tx) & gate_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_src_q <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      tx_src_q <= tx_src_d;
      irq_q    <= irq_d;
    end
  end

  assign irq_o = irq_q;

  // R10: a rising transmit enable arms the transmit source
  assert_tx_arm_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ier_wr_i && ier_wtx_i && !ier_i[IER_TX]) |=> tx_src_q);
  // R9: reading the transmit code clears the transmit source
  assert_tx_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (iir_rd_i && iir_o[3:0] == ID_TX && !tx_set_i) |=> !tx_src_q);
  // R11: the line never rises without the gate
  assert_irq_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(gate_i));
endmodule

// File: rtl/uart_host_regs.sv
module uart_host_regs
  import uart_host_pkg::*;
#(
  parameter int          ADDR_W       = 8,
  parameter int          STRIDE_SHIFT = 0,
  parameter logic [15:0] DIV_RESET    = 16'd12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              irq,
  output logic              tx_push,
  output logic [7:0]        tx_byte,
  output logic              rx_pop,
  input  logic [7:0]        rx_byte,
  input  logic              rx_avail,
  input  logic              rx_present
);
  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_sync;
  logic                   rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync[SYNC_STAGES-1];

  bus_op_t op;
  uart_host_decode #(.ADDR_W(ADDR_W), .STRIDE_SHIFT(STRIDE_SHIFT)) i_decode (
    .sel_i(bus_sel), .wr_i(bus_wr), .addr_i(bus_addr), .op_o(op));

  logic [7:0]  lcr_q, lcr_d, mcr_q, mcr_d, ier_q, ier_d, fcr_q, fcr_d, scr_q, scr_d;
  logic [15:0] div_q, div_d;
  logic        dlab, loop_on;
  logic        data_wr, data_rd, ier_wr, iir_rd;
  logic        rx_ready;
  logic [7:0]  rx_rd_byte, iir_val;

  always_comb begin
    dlab    = lcr_q[LCR_DLAB];
    loop_on = mcr_q[MCR_LOOP];
    data_wr = op.wr && op.off == OFF_DATA && !dlab;
    data_rd = op.rd && op.off == OFF_DATA && !dlab;
    ier_wr  = op.wr && op.off == OFF_IER && !dlab;
    iir_rd  = op.rd && op.off == OFF_IIR;
  end

  always_comb begin
    lcr_d = lcr_q; mcr_d = mcr_q; ier_d = ier_q;
    fcr_d = fcr_q; scr_d = scr_q; div_d = div_q;
    if (op.wr) begin
      unique case (op.off)
        OFF_DATA: if (dlab) div_d[7:0]  = bus_wdata;
        OFF_IER:  if (dlab) div_d[15:8] = bus_wdata;
                  else      ier_d       = bus_wdata;
        OFF_IIR:  fcr_d = bus_wdata;
        OFF_LCR:  lcr_d = bus_wdata;
        OFF_MCR:  mcr_d = bus_wdata;
        OFF_SCR:  scr_d = bus_wdata;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      lcr_q <= LCR_RESET;
      mcr_q <= '0;
      ier_q <= '0;
      fcr_q <= '0;
      scr_q <= '0;
      div_q <= DIV_RESET;
    end else if (op.wr) begin
      lcr_q <= lcr_d;
      mcr_q <= mcr_d;
      ier_q <= ier_d;
      fcr_q <= fcr_d;
      scr_q <= scr_d;
      div_q <= div_d;
    end
  end

  uart_host_rxpath #(.DATA_W(8)) i_rxpath (
    .clk(clk), .rst_n(rst_int_n), .loop_i(loop_on),
    .wr_i(data_wr), .rd_i(data_rd), .wdata_i(bus_wdata),
    .rx_byte_i(rx_byte), .rx_avail_i(rx_avail), .rx_present_i(rx_present),
    .rx_ready_o(rx_ready), .rd_byte_o(rx_rd_byte), .rx_pop_o(rx_pop));

  uart_host_irq i_irq (
    .clk(clk), .rst_n(rst_int_n), .ier_i(ier_q[1:0]),
    .ier_wr_i(ier_wr), .ier_wtx_i(bus_wdata[IER_TX]), .tx_set_i(data_wr),
    .rx_ready_i(rx_ready), .iir_rd_i(iir_rd), .fifo_on_i(fcr_q[0]),
    .gate_i(mcr_q[MCR_OUT2]), .iir_o(iir_val), .irq_o(irq));

  assign tx_push = data_wr & ~loop_on;
  assign tx_byte = bus_wdata;

  always_comb begin
    unique case (op.off)
      OFF_DATA: bus_rdata = dlab ? div_q[7:0] : rx_rd_byte;
      OFF_IER:  bus_rdata = dlab ? div_q[15:8] : ier_q;
      OFF_IIR:  bus_rdata = iir_val;
      OFF_LCR:  bus_rdata = lcr_q;
      OFF_MCR:  bus_rdata = mcr_q;
      OFF_LSR:  bus_rdata = LSR_TX_IDLE | {7'd0, rx_ready};
      OFF_MSR:  bus_rdata = MSR_FIXED;
      default:  bus_rdata = scr_q;
    endcase
  end

  // R3: divisor low byte captured on a latched-access write
  assert_div_low_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (op.wr && op.off == OFF_DATA && dlab) |=> div_q[7:0] == $past(bus_wdata));
  // R3, R6: no transmit push during divisor access or loopback
  assert_push_mode_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    tx_push |-> (!lcr_q[LCR_DLAB] && !mcr_q[MCR_LOOP] && bus_sel));
  // R8: a pop only happens while the receiver offers a byte
  assert_pop_avail_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    rx_pop |-> (rx_avail && rx_present && bus_sel && !bus_wr));
endmodule

// File: tb/test_uart_host_regs.sv
module test_uart_host_regs;
  localparam int AW = 8;
  localparam int SH = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_sel = 1'b0, bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [7:0]    bus_wdata = '0;
  logic [7:0]    bus_rdata, tx_byte;
  logic          irq, tx_push, rx_pop;
  logic [7:0]    rx_byte = 8'h00;
  logic          rx_avail = 1'b0, rx_present = 1'b0;

  int checks = 0, errors = 0;
  int push_cnt = 0, pop_cnt = 0;
  logic [7:0] last_tx = '0;

  always #10 clk = ~clk;

  uart_host_regs #(.ADDR_W(AW), .STRIDE_SHIFT(SH)) i_uart_host_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .tx_push(tx_push), .tx_byte(tx_byte), .rx_pop(rx_pop),
    .rx_byte(rx_byte), .rx_avail(rx_avail), .rx_present(rx_present));

  always @(posedge clk) begin
    if (tx_push) begin push_cnt <= push_cnt + 1; last_tx <= tx_byte; end
    if (rx_pop) pop_cnt <= pop_cnt + 1;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr_addr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd_addr(input logic [AW-1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #5 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic wr(input int off, input logic [7:0] d);
    wr_addr(AW'(off << SH), d);
  endtask

  task automatic rd_chk(input int off, input int exp, input string req);
    logic [7:0] v;
    rd_addr(AW'(off << SH), v);
    check(req, int'(v), exp);
  endtask

  task automatic t_reset;
    check("R2 irq", int'(irq), 0);
    rd_chk(3, 8'h03, "R2 lcr");
    rd_chk(1, 8'h00, "R2 ier");
    rd_chk(4, 8'h00, "R2 mcr");
    rd_chk(2, 8'h01, "R2 iir");
    wr(3, 8'h83);
    rd_chk(0, 12, "R2 div low");
    rd_chk(1, 0, "R2 div high");
  endtask

  task automatic t_divisor;
    int p0;
    p0 = push_cnt;
    wr(0, 8'h34);
    wr(1, 8'h12);
    rd_chk(0, 8'h34, "R3 div low");
    rd_chk(1, 8'h12, "R3 div high");
    check("R3 no push", push_cnt, p0);
    wr(3, 8'h03);
    rd_chk(1, 8'h00, "R3 ier untouched");
    wr(3, 8'h83);
    rd_chk(0, 8'h34, "R3 div kept");
    wr(3, 8'h03);
  endtask

  task automatic t_status;
    wr(5, 8'hFF);
    rd_chk(5, 8'h60, "R4 lsr");
    wr(6, 8'h00);
    rd_chk(6, 8'hB0, "R5 msr");
  endtask

  task automatic t_tx_irq;
    int p0;
    p0 = push_cnt;
    wr(0, 8'hA5);
    check("R6 push count", push_cnt, p0 + 1);
    check("R6 tx byte", int'(last_tx), 8'hA5);
    rd_chk(2, 8'h01, "R11 masked iir");
    wr(4, 8'h08);
    wr(1, 8'h02);
    @(negedge clk);
    check("R11 irq high", int'(irq), 1);
    rd_chk(2, 8'h02, "R9 tx code");
    rd_chk(2, 8'h01, "R9 tx cleared");
    check("R9 irq low", int'(irq), 0);
    wr(1, 8'h00);
    wr(1, 8'h02);
    rd_chk(2, 8'h02, "R10 rise arms");
    wr(1, 8'h02);
    rd_chk(2, 8'h01, "R10 no rise");
    wr(2, 8'h01);
    rd_chk(2, 8'hC1, "R9 fifo bits");
    wr(2, 8'h00);
  endtask

  task automatic t_rx;
    int q0;
    rx_present = 1'b1; rx_avail = 1'b1; rx_byte = 8'h3C;
    rd_chk(5, 8'h61, "R4 lsr ready");
    wr(0, 8'h11);
    wr(1, 8'h03);
    rd_chk(2, 8'h04, "R9 rx priority");
    check("R11 irq rx", int'(irq), 1);
    q0 = pop_cnt;
    rd_chk(0, 8'h3C, "R8 data");
    check("R8 pop", pop_cnt, q0 + 1);
    rx_avail = 1'b0;
    rd_chk(2, 8'h02, "R9 tx after rx");
    rx_avail = 1'b1;
    wr(4, 8'h00);
    @(negedge clk);
    check("R11 gated", int'(irq), 0);
    rx_present = 1'b0;
    q0 = pop_cnt;
    rd_chk(0, 8'h00, "R8 absent");
    check("R8 no pop", pop_cnt, q0);
    rx_avail = 1'b0;
  endtask

  task automatic t_loop;
    int p0;
    p0 = push_cnt;
    wr(4, 8'h10);
    wr(0, 8'h77);
    check("R7 no push", push_cnt, p0);
    rd_chk(5, 8'h61, "R7 ready");
    rd_chk(0, 8'h77, "R7 data");
    rd_chk(5, 8'h60, "R7 empty");
    wr(4, 8'h00);
  endtask

  task automatic t_stride;
    logic [7:0] v;
    wr_addr(AW'((7 << SH) | 3), 8'h5A);
    rd_addr(AW'(7 << SH), v);
    check("R1 R12 scratch", int'(v), 8'h5A);
    rd_addr(AW'((3 << SH) | 1), v);
    check("R1 low bits", int'(v), 8'h03);
  endtask

  initial begin
    fork
      begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_reset();
        t_divisor();
        t_status();
        t_tx_irq();
        t_rx();
        t_loop();
        t_stride();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule